// File: doc/BRIEF.md
# TDM Time-Slot Routing Sequencer

This block walks a small table of 16-bit routing entries in step with a serial TDM bit clock. Each entry covers a run of consecutive bits or bytes on the serial line. For that run, the block reports which logical channel the bits belong to, whether the run is the opening byte of a superchannel, and whether loopback or echo is requested for it. A frame begins on a frame sync pulse sampled on a bit tick. The block then steps through the entries from entry 0 and stops after the entry marked last. It then idles until the next sync.

The bit clock is a one-cycle enable (`bit_tick`) inside the system clock domain. All outputs are level signals that describe the bit currently on the line, and they move on to the next bit on each ticking edge. The table can be loaded through a simple write port, but only while the sequencer idles between frames. Two parameters choose the table's direction (receive or transmit) and whether it belongs to the second serial interface instance, where the channel number's top bit is always forced to 1.

Top module: `tdm_slot_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to the idle state at entry 0 and clears every table entry. While idle, all outputs are 0.
- R2: In the idle state, a clock edge with `bit_tick` and `frame_sync` both high starts a frame. From the next cycle on, the outputs describe bit 0 of entry 0.
- R3: An entry covers (count+1) units, where count is data bits [13:11]. Bit [14] selects the unit: 0 means single bits and 1 means bytes of 8 bits. Each ticking edge consumes one bit.
- R4: `chan_valid` is 1 for every bit of an entry whose bit [0] is 1, and `chan_id` then carries bits [10:3]. Entries with bit [0] at 0 still use up their bits, but all outputs stay 0 during them.
- R5: The last flag in bit [15] ends the frame only in an odd-numbered entry. In an even-numbered entry it is ignored and the next entry follows.
- R6: After the frame ends, the outputs stay 0 until the next sync. A sync that arrives while a frame is running has no effect.
- R7: When bit [2] is set, the entry always covers 8 bits. Count 000 with the byte unit raises `super_first`. Count 111 with the bit unit marks a following byte, with both flags low. Any other pairing raises `super_err`.
- R8: Bit [1] of a routed entry drives `loop_en` when the table is a receive table (IS_TX=0) and `echo_en` when it is a transmit table (IS_TX=1). The two outputs are never high together.
- R9: With FORCE_HI=1, `chan_id[7]` reads as 1 whatever value was written.
- R10: A write issued while a frame is running leaves the table unchanged.
- R11: When the frame reaches entry DEPTH-1, it ends after that entry even if no last flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle serial bit clock enable |
| frame_sync | input | 1 | Frame sync, sampled on a bit tick |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | $clog2(DEPTH) | Table entry address |
| wr_data | input | 16 | Entry value |
| chan_valid | output | 1 | Current bit is routed to a channel |
| chan_id | output | 8 | Channel of the current bit |
| super_first | output | 1 | Current byte opens a superchannel |
| super_err | output | 1 | Superchannel entry has an illegal count/unit pair |
| loop_en | output | 1 | Loopback requested (receive table) |
| echo_en | output | 1 | Echo requested (transmit table) |

## Verification
The hardest case to reach from the ports is a write that lands during a running frame. It changes nothing visible until a later frame reads the same entry. The bench therefore writes entry 0 during that entry's own first bit. It lets the frame finish, starts a second frame, and confirms that the old channel number comes back. A last flag placed in an even entry is covered the same way: the bench follows the channel sequence past that entry.

// File: rtl/tdm_route_pkg.sv
// Package: shared entry layout for the time-slot routing sequencer.
// Assumes 16-bit entries. The field order below fixes the bit positions
// that software writes.
package tdm_route_pkg;

    localparam int ENTRY_W = 16;
    localparam int LEN_W   = 7;   // up to 64 bits per entry

    typedef struct packed {
        logic       last;      // [15]
        logic       byte_unit; // [14]
        logic [2:0] count;     // [13:11]
        logic [7:0] chan;      // [10:3]
        logic       super_ch;  // [2]
        logic       loop_echo; // [1]
        logic       route;     // [0]
    } route_entry_t;

endpackage

// File: rtl/tdm_entry_decode.sv
// Module: tdm_entry_decode
// Turns one table entry into its run length in bits and its superchannel
// flags. Purely combinational. Assumes the caller qualifies the flags with
// the route bit and the running state.
module tdm_entry_decode
    import tdm_route_pkg::*;
(
    input  route_entry_t     ent,
    output logic [LEN_W-1:0] len_bits,
    output logic             sup_first,
    output logic             sup_bad
);

    logic first_pat;
    logic follow_pat;

    // Recognize the two legal superchannel encodings.
    always_comb begin
        first_pat  = (ent.count == 3'd0) && ent.byte_unit;
        follow_pat = (ent.count == 3'd7) && !ent.byte_unit;
    end

    // Length in bits and superchannel classification.
    always_comb begin
        if (ent.super_ch) begin
            len_bits  = LEN_W'(8);
            sup_first = first_pat;
            sup_bad   = !(first_pat || follow_pat);
        end else begin
            len_bits  = ent.byte_unit ? {1'b0, ent.count, 3'b000} + LEN_W'(8)
                                      : {4'b0000, ent.count} + LEN_W'(1);
            sup_first = 1'b0;
            sup_bad   = 1'b0;
        end
    end

endmodule

// File: rtl/tdm_slot_mem.sv
// Module: tdm_slot_mem
// Routing table storage with an asynchronous read port. A write goes
// through only when wr_allow is high, which the sequencer raises only
// while idle. Assumes DEPTH is small enough to build from flops.
module tdm_slot_mem
    import tdm_route_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_allow,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);

    logic [DEPTH-1:0][ENTRY_W-1:0] mem_q;

    // Clear on reset; store gated writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (wr_en && wr_allow) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Asynchronous read of the entry in use.
    always_comb rd_data = mem_q[rd_addr];

    // R10: a write during a frame leaves the table unchanged.
    p_locked_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_allow) |=> (mem_q == $past(mem_q)));

endmodule

// File: rtl/tdm_slot_seq.sv
// Module: tdm_slot_seq
// Frame sequencer that tracks the entry index and the bit position within
// the current entry. Starts on sync while idle. Ends after a last-flagged
// odd entry or after entry DEPTH-1. Assumes DEPTH is even.
module tdm_slot_seq
    import tdm_route_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             frame_sync,
    input  logic [LEN_W-1:0] len_bits,
    input  logic             last_flag,
    output logic             running,
    output logic [AW-1:0]    idx
);

    logic [LEN_W-1:0] bit_pos;
    logic             entry_done;
    logic             frame_done;

    // Detect the final bit of the entry and the end of the frame.
    always_comb begin
        entry_done = (bit_pos == len_bits - LEN_W'(1));
        frame_done = (last_flag && idx[0]) || (idx == AW'(DEPTH - 1));
    end

    // Step the index and bit counter on each bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            idx     <= '0;
            bit_pos <= '0;
        end else if (bit_tick) begin
            if (!running) begin
                running <= frame_sync;
                idx     <= '0;
                bit_pos <= '0;
            end else if (entry_done) begin
                bit_pos <= '0;
                if (frame_done) begin
                    running <= 1'b0;
                    idx     <= '0;
                end else begin
                    idx <= idx + AW'(1);
                end
            end else begin
                bit_pos <= bit_pos + LEN_W'(1);
            end
        end
    end

    // R1: the idle state always sits at entry 0, bit 0.
    p_idle_home_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (idx == '0 && bit_pos == '0));

    // R3: the bit position stays inside the entry's length.
    p_pos_in_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (bit_pos < len_bits));

    // R5: a frame only ends in an odd-numbered entry.
    p_end_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(idx[0]));

    // R6: a sync before the entry's last bit does not restart or stop the frame.
    p_sync_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && bit_tick && frame_sync && !entry_done) |=> (running && $stable(idx)));

endmodule

// File: rtl/tdm_slot_router.sv
// Module: tdm_slot_router (top)
// Routes TDM bits to logical channels by walking the routing table.
// IS_TX picks whether bit [1] means loopback (receive) or echo (transmit).
// FORCE_HI forces the top channel bit, as on the second interface instance.
module tdm_slot_router
    import tdm_route_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter bit IS_TX    = 1'b0,
    parameter bit FORCE_HI = 1'b0,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic          frame_sync,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [15:0]   wr_data,
    output logic          chan_valid,
    output logic [7:0]    chan_id,
    output logic          super_first,
    output logic          super_err,
    output logic          loop_en,
    output logic          echo_en
);

    logic               running;
    logic [AW-1:0]      idx;
    logic [ENTRY_W-1:0] rd_raw;
    route_entry_t       cur;
    logic [LEN_W-1:0]   len_bits;
    logic               sup_first_d;
    logic               sup_bad_d;
    logic               active;
    logic [7:0]         chan_eff;

    tdm_slot_mem #(.DEPTH(DEPTH)) mem_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_allow (!running),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (idx),
        .rd_data  (rd_raw)
    );

    tdm_entry_decode dec_i (
        .ent       (cur),
        .len_bits  (len_bits),
        .sup_first (sup_first_d),
        .sup_bad   (sup_bad_d)
    );

    tdm_slot_seq #(.DEPTH(DEPTH)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .frame_sync (frame_sync),
        .len_bits   (len_bits),
        .last_flag  (cur.last),
        .running    (running),
        .idx        (idx)
    );

    // Reinterpret the raw table word as the entry layout.
    always_comb cur = route_entry_t'(rd_raw);

    // Apply the instance-specific channel MSB override.
    generate
        if (FORCE_HI) begin : g_hi
            always_comb chan_eff = {1'b1, cur.chan[6:0]};
        end else begin : g_lo
            always_comb chan_eff = cur.chan;
        end
    endgenerate

    // Qualify every output with a routed entry in a running frame.
    always_comb begin
        active      = running && cur.route;
        chan_valid  = active;
        chan_id     = active ? chan_eff : 8'd0;
        super_first = active && cur.super_ch && sup_first_d;
        super_err   = active && cur.super_ch && sup_bad_d;
        loop_en     = active && cur.loop_echo && !IS_TX;
        echo_en     = active && cur.loop_echo && IS_TX;
    end

    // R4/R6: no routed bit while the frame is idle.
    p_valid_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !(chan_valid || super_first || loop_en || echo_en));

    // R7: a legal first byte never flags an error.
    p_first_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        super_first |-> !super_err);

    // R8: loopback and echo are mutually exclusive.
    p_no_loop_echo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(loop_en && echo_en));

    // R9: the forced instance always reports the high channel half.
    p_hi_msb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (FORCE_HI && chan_valid) |-> chan_id[7]);

endmodule

// File: tb/tdm_slot_router_tb_top.sv
// Directed bench for tdm_slot_router. A receive table and a high-half
// transmit table share the same inputs.
module tdm_slot_router_tb_top;

    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_tick = 1'b0;
    logic          frame_sync = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic          chan_valid, super_first, super_err, loop_en, echo_en;
    logic [7:0]    chan_id;
    logic          h_valid, h_first, h_err, h_loop, h_echo;
    logic [7:0]    h_chan;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tdm_slot_router #(.DEPTH(DEPTH), .IS_TX(1'b0), .FORCE_HI(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_sync(frame_sync),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .chan_valid(chan_valid), .chan_id(chan_id), .super_first(super_first),
        .super_err(super_err), .loop_en(loop_en), .echo_en(echo_en));

    tdm_slot_router #(.DEPTH(DEPTH), .IS_TX(1'b1), .FORCE_HI(1'b1)) dut_hi_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_sync(frame_sync),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .chan_valid(h_valid), .chan_id(h_chan), .super_first(h_first),
        .super_err(h_err), .loop_en(h_loop), .echo_en(h_echo));

    function automatic logic [15:0] ent(input bit route, input bit lp, input bit sup,
                                        input int ch, input int cnt, input bit byt,
                                        input bit last);
        return {last, byt, 3'(cnt), 8'(ch), sup, lp, route};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Move one clock edge ahead and settle past it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic start_frame();
        bit_tick = 1'b1; frame_sync = 1'b1;
        tick();
        frame_sync = 1'b0;
    endtask

    // Expect n routed bits of channel ch, one per tick.
    task automatic expect_run(input int ch, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk(chan_valid && chan_id == 8'(ch), req, int'(chan_id), ch);
            tick();
        end
    endtask

    task automatic expect_idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk(!chan_valid && chan_id == 8'd0, req, int'(chan_valid), 0);
            tick();
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        chk(!chan_valid && !super_first && !super_err && !loop_en && !echo_en,
            "R1 outputs after reset", int'(chan_valid), 0);
        // R1: cleared table, so a frame routes nothing.
        start_frame();
        chk(!chan_valid, "R1 cleared table", int'(chan_valid), 0);
        for (int i = 0; i < DEPTH; i++) tick();
        expect_idle(2, "R1 idle after empty frame");
    endtask

    task automatic t_basic();
        wr(0, ent(1, 0, 0, 5, 2, 0, 0));
        wr(1, ent(1, 0, 0, 9, 0, 1, 1));
        bit_tick = 1'b1;
        expect_idle(2, "R2 no start without sync");
        start_frame();
        expect_run(5, 3, "R3 three bits ch5");
        expect_run(9, 8, "R3 one byte ch9");
        expect_idle(3, "R6 idle after last");
    endtask

    task automatic t_even_last();
        wr(0, ent(1, 0, 0, 1, 0, 0, 1));
        wr(1, ent(1, 0, 0, 2, 1, 0, 0));
        wr(2, ent(1, 0, 0, 3, 0, 0, 0));
        wr(3, ent(1, 0, 0, 4, 0, 0, 1));
        start_frame();
        expect_run(1, 1, "R5 even last ignored e0");
        frame_sync = 1'b1;               // R6: mid-frame sync
        expect_run(2, 2, "R6 mid-frame sync ignored");
        frame_sync = 1'b0;
        expect_run(3, 1, "R5 e2 follows");
        expect_run(4, 1, "R5 odd last ends");
        expect_idle(4, "R6 waits for sync");
    endtask

    task automatic t_unrouted_loop();
        wr(0, ent(0, 1, 0, 33, 3, 0, 0));
        wr(1, ent(1, 1, 0, 7, 0, 0, 1));
        start_frame();
        for (int i = 0; i < 4; i++) begin
            chk(!chan_valid && !loop_en && chan_id == 0, "R4 unrouted entry silent",
                int'(chan_id), 0);
            tick();
        end
        chk(chan_valid && chan_id == 7, "R4 routed after unrouted", int'(chan_id), 7);
        chk(loop_en && !echo_en, "R8 rx loopback", int'(loop_en), 1);
        chk(h_echo && !h_loop, "R8 tx echo", int'(h_echo), 1);
        chk(h_chan == 8'd135, "R9 forced msb", int'(h_chan), 135);
        tick();
        expect_idle(1, "R4 idle after frame");
    endtask

    task automatic t_super();
        wr(0, ent(1, 0, 1, 20, 0, 1, 0));
        wr(1, ent(1, 0, 1, 20, 7, 0, 0));
        wr(2, ent(1, 0, 1, 20, 3, 1, 0));
        wr(3, ent(1, 0, 0, 1, 0, 0, 1));
        start_frame();
        for (int i = 0; i < 8; i++) begin
            chk(super_first && !super_err && chan_id == 20, "R7 first byte",
                int'(super_first), 1);
            tick();
        end
        for (int i = 0; i < 8; i++) begin
            chk(!super_first && !super_err && chan_id == 20, "R7 following byte",
                int'(super_first), 0);
            tick();
        end
        for (int i = 0; i < 8; i++) begin
            chk(super_err && !super_first && chan_id == 20, "R7 illegal pair one byte",
                int'(super_err), 1);
            tick();
        end
        expect_run(1, 1, "R7 after superchannel");
        expect_idle(1, "R7 frame end");
    endtask

    task automatic t_locked_write();
        wr(0, ent(1, 0, 0, 10, 3, 0, 0));
        wr(1, ent(1, 0, 0, 12, 0, 0, 1));
        start_frame();
        wr_en = 1'b1; wr_addr = '0; wr_data = ent(1, 0, 0, 11, 3, 0, 0);
        chk(chan_id == 10, "R10 before write", int'(chan_id), 10);
        tick();
        wr_en = 1'b0;
        expect_run(10, 3, "R10 current frame intact");
        expect_run(12, 1, "R10 e1");
        expect_idle(1, "R10 idle");
        start_frame();
        expect_run(10, 4, "R10 write dropped");
        expect_run(12, 1, "R10 e1 again");
    endtask

    task automatic t_slow_tick();
        wr(0, ent(1, 0, 0, 3, 1, 0, 0));
        wr(1, ent(1, 0, 0, 4, 0, 0, 1));
        start_frame();
        for (int b = 0; b < 2; b++) begin
            bit_tick = 1'b0;
            chk(chan_id == 3, "R3 held between ticks", int'(chan_id), 3);
            tick();
            chk(chan_id == 3, "R3 no advance without tick", int'(chan_id), 3);
            bit_tick = 1'b1;
            tick();
        end
        chk(chan_id == 4, "R3 two bits then next entry", int'(chan_id), 4);
        tick();
        expect_idle(1, "R3 slow frame end");
    endtask

    task automatic t_table_end();
        for (int i = 0; i < DEPTH; i++) wr(i, ent(1, 0, 0, 40 + i, 0, 0, 0));
        start_frame();
        for (int i = 0; i < DEPTH; i++) expect_run(40 + i, 1, "R11 walk table");
        expect_idle(3, "R11 ends at last index");
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_even_last();
        t_unrouted_loop();
        t_super();
        t_locked_write();
        t_slow_tick();
        t_table_end();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule